// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a NOR-style flash device. Every bus write of a command byte passes through it. It decodes one-cycle commands and two-cycle setup/confirm sequences from the low byte of a 16-bit data bus. It chooses what later bus reads return: array contents, a status byte, or identifier codes. It also turns completed erase and word-write sequences into a one-cycle request toward an external write-state-machine (WSM).

The flash array, the erase and program algorithms and analog voltage sensing are all outside the block. It sees them only as a busy handshake and level inputs: `vpp_ok` (programming voltage above lockout), `wp_n` (write protect, active low) and `rp_hv` (reset pin at its high-voltage level). The block holds a status byte with ready, suspended and error flags, and it forwards suspend and resume requests to the WSM.

The states are:
- `ST_ARRAY`: array read.
- `ST_IDENT`: identifier read.
- `ST_STATUS`: status read.
- `ST_ERASE_ARM`: waiting for the erase confirm.
- `ST_WRITE_ARM`: waiting for write data.

The transitions are:
- Read-mode commands move between the three read states.
- The erase setup moves to `ST_ERASE_ARM`.
- Either write setup moves to `ST_WRITE_ARM`.
- Any second cycle leaves an arm state for `ST_STATUS`.
- Suspend always lands in `ST_STATUS`.
- Resume lands in `ST_STATUS` when a suspension is active.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and after a write of code FFh, reads return `arr_rdata` unchanged (array mode).
- R2: After code 90h, a read at address 0 returns parameter MFR_CODE, a read at address 1 returns DEV_CODE, and a read at any other address returns zero.
- R3: After code 70h, reads return the status byte in bits 7:0 with zero above. Its bits are:
  - bit 7: ready, equal to !wsm_busy.
  - bit 6: suspended.
  - bit 5: erase error.
  - bit 4: write error.
  - bit 3: voltage-lockout error.
  - bit 1: locked-block error.
  - bits 2 and 0: zero.
  Code 50h clears bits 5, 4, 3 and 1 and does not change the read mode.
- R4: Code 20h followed by D0h produces a one-cycle `wsm_req` with `wsm_erase`=1. It comes in the cycle after the confirm write, and `wsm_addr` equals the confirm address.
- R5: A setup of 40h or 10h followed by any data word produces a one-cycle `wsm_req` with `wsm_erase`=0. `wsm_addr` and `wsm_wdata` equal the address and data of the second write.
- R6: Code B0h while `wsm_busy` is high and nothing is suspended raises `wsm_suspend` and status bit 6. Code D0h while suspended lowers both.
- R7: With `vpp_ok` low, a completed erase or write sequence issues no request. It sets bit 3 together with bit 5 (erase) or bit 4 (write). Array reads still work.
- R8: Codes outside FFh, 90h, 70h, 50h, 20h, 40h, 10h, B0h and D0h, written in a read mode, issue no request and leave the read mode unchanged.
- R9: After an erase or write setup, a second cycle, or a suspend command, reads return the status byte.
- R10: A second erase cycle other than D0h issues no request, sets bits 5 and 4, and enters status mode.
- R11: An operation whose address has its top BLK_BITS bits all zero (the boot block) is refused while `wp_n` is low and `rp_hv` is low. No request is issued, and bit 1 is set with the operation's error bit. With `rp_hv` high it proceeds.
- R12: A completed sequence while `wsm_busy` is high or while suspended issues no request and sets no error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | One-cycle bus write strobe (already synchronized) |
| bus_addr | input | AW | Address for writes and reads |
| cmd_data | input | DW | Write data; commands decoded from bits 7:0 |
| arr_rdata | input | DW | Array read data |
| rd_data | output | DW | Read data for the current read mode |
| vpp_ok | input | 1 | Programming voltage above lockout |
| wp_n | input | 1 | Write protect, active low |
| rp_hv | input | 1 | Reset pin at high-voltage level |
| wsm_busy | input | 1 | WSM operation running |
| wsm_req | output | 1 | One-cycle operation launch |
| wsm_erase | output | 1 | Launched operation is an erase |
| wsm_addr | output | AW | Target address of the launch |
| wsm_wdata | output | DW | Word-write data of the launch |
| wsm_suspend | output | 1 | Suspend request, held until resume |

## Verification
The bench builds the block with AW=8 and BLK_BITS=2, so the boot block is addresses 00h to 3Fh. This makes both locked and unlocked targets reachable with short addresses. It sets MFR_CODE=0089h and DEV_CODE=0017h, which differ from the defaults and from each other, so identifier decoding is visible. A WSM model in the bench holds busy for six unsuspended cycles. That window is long enough to land a suspend, a resume and a launch attempt during busy, and short enough to wait out each operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_IDENT,
        ST_STATUS,
        ST_ERASE_ARM,
        ST_WRITE_ARM
    } fc_state_t;

    typedef enum logic [3:0] {
        K_ARRAY,
        K_IDENT,
        K_STATUS,
        K_CLEAR,
        K_ERASE,
        K_WRITE,
        K_SUSPEND,
        K_CONFIRM,
        K_RSVD
    } fc_kind_t;

    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_WRITE_A = 8'h40;
    localparam logic [7:0] OP_WRITE_B = 8'h10;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;

    localparam int SB_READY = 7;
    localparam int SB_SUSP  = 6;
    localparam int SB_ERASE = 5;
    localparam int SB_WRITE = 4;
    localparam int SB_VPP   = 3;
    localparam int SB_LOCK  = 1;

endpackage

// File: rtl/fci_decode.sv
module fci_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output fc_kind_t   kind
);

    always_comb begin
        case (code)
            OP_ARRAY:               kind = K_ARRAY;
            OP_IDENT:               kind = K_IDENT;
            OP_STATUS:              kind = K_STATUS;
            OP_CLEAR:               kind = K_CLEAR;
            OP_ERASE:               kind = K_ERASE;
            OP_WRITE_A, OP_WRITE_B: kind = K_WRITE;
            OP_SUSPEND:             kind = K_SUSPEND;
            OP_CONFIRM:             kind = K_CONFIRM;
            default:                kind = K_RSVD;
        endcase
    end

endmodule

// File: rtl/fci_gate.sv
module fci_gate #(
    parameter int AW       = 12,
    parameter int BLK_BITS = 3
) (
    input  logic [AW-1:0] addr,
    input  logic          vpp_ok,
    input  logic          wp_n,
    input  logic          rp_hv,
    output logic          blk_vpp,
    output logic          blk_lock
);

    localparam int TOP = AW - 1;

    logic in_boot;

    assign in_boot  = (addr[TOP -: BLK_BITS] == '0);
    assign blk_vpp  = !vpp_ok;
    assign blk_lock = in_boot && !wp_n && !rp_hv;

endmodule

// File: rtl/fci_readmux.sv
module fci_readmux
    import flash_cmd_pkg::*;
#(
    parameter int          AW       = 12,
    parameter int          DW       = 16,
    parameter logic [15:0] MFR_CODE = 16'h00B0,
    parameter logic [15:0] DEV_CODE = 16'h00E9
) (
    input  fc_state_t     state,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic [7:0]    status,
    output logic [DW-1:0] rd_data
);

    localparam logic [DW-1:0] MFR_W = DW'(MFR_CODE);
    localparam logic [DW-1:0] DEV_W = DW'(DEV_CODE);

    logic [DW-1:0] id_word;
    logic [DW-1:0] stat_word;

    always_comb begin
        if (addr == AW'(0))
            id_word = MFR_W;
        else if (addr == AW'(1))
            id_word = DEV_W;
        else
            id_word = '0;
    end

    assign stat_word = {{(DW-8){1'b0}}, status};

    always_comb begin
        unique case (state)
            ST_ARRAY: rd_data = arr_rdata;
            ST_IDENT: rd_data = id_word;
            default:  rd_data = stat_word;
        endcase
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int          AW       = 12,
    parameter int          BLK_BITS = 3,
    parameter int          DW       = 16,
    parameter logic [15:0] MFR_CODE = 16'h00B0,
    parameter logic [15:0] DEV_CODE = 16'h00E9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_data,
    input  logic          vpp_ok,
    input  logic          wp_n,
    input  logic          rp_hv,
    input  logic          wsm_busy,
    output logic          wsm_req,
    output logic          wsm_erase,
    output logic [AW-1:0] wsm_addr,
    output logic [DW-1:0] wsm_wdata,
    output logic          wsm_suspend
);

    fc_state_t     state_q, state_d;
    fc_kind_t      kind;
    logic          susp_q, susp_d;
    logic [7:0]    err_q, err_d;
    logic          req_d, erase_d;
    logic [AW-1:0] addr_d;
    logic [DW-1:0] wdata_d;
    logic          try_launch, try_erase;
    logic          blk_vpp, blk_lock;
    logic [7:0]    status;

    fci_decode u_decode (
        .code (cmd_data[7:0]),
        .kind (kind)
    );

    fci_gate #(.AW(AW), .BLK_BITS(BLK_BITS)) u_gate (
        .addr     (bus_addr),
        .vpp_ok   (vpp_ok),
        .wp_n     (wp_n),
        .rp_hv    (rp_hv),
        .blk_vpp  (blk_vpp),
        .blk_lock (blk_lock)
    );

    always_comb begin
        status           = err_q;
        status[SB_READY] = !wsm_busy;
        status[SB_SUSP]  = susp_q;
    end

    fci_readmux #(
        .AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_readmux (
        .state     (state_q),
        .addr      (bus_addr),
        .arr_rdata (arr_rdata),
        .status    (status),
        .rd_data   (rd_data)
    );

    // Next-state and launch decision
    always_comb begin
        state_d    = state_q;
        susp_d     = susp_q;
        err_d      = err_q;
        req_d      = 1'b0;
        erase_d    = wsm_erase;
        addr_d     = wsm_addr;
        wdata_d    = wsm_wdata;
        try_launch = 1'b0;
        try_erase  = 1'b0;
        if (cmd_we) begin
            unique case (state_q)
                ST_ERASE_ARM: begin
                    state_d = ST_STATUS;
                    if (kind == K_CONFIRM) begin
                        try_launch = 1'b1;
                        try_erase  = 1'b1;
                    end else begin
                        err_d[SB_ERASE] = 1'b1;
                        err_d[SB_WRITE] = 1'b1;
                    end
                end
                ST_WRITE_ARM: begin
                    state_d    = ST_STATUS;
                    try_launch = 1'b1;
                end
                default: begin
                    unique case (kind)
                        K_ARRAY:  state_d = ST_ARRAY;
                        K_IDENT:  state_d = ST_IDENT;
                        K_STATUS: state_d = ST_STATUS;
                        K_CLEAR:  err_d   = '0;
                        K_ERASE:  state_d = ST_ERASE_ARM;
                        K_WRITE:  state_d = ST_WRITE_ARM;
                        K_SUSPEND: begin
                            state_d = ST_STATUS;
                            if (wsm_busy && !susp_q)
                                susp_d = 1'b1;
                        end
                        K_CONFIRM: begin
                            if (susp_q) begin
                                susp_d  = 1'b0;
                                state_d = ST_STATUS;
                            end
                        end
                        K_RSVD: ;
                    endcase
                end
            endcase
        end
        if (try_launch && !wsm_busy && !susp_q) begin
            if (blk_vpp || blk_lock) begin
                err_d[SB_VPP]  = err_d[SB_VPP] | blk_vpp;
                err_d[SB_LOCK] = err_d[SB_LOCK] | (blk_lock && !blk_vpp);
                if (try_erase)
                    err_d[SB_ERASE] = 1'b1;
                else
                    err_d[SB_WRITE] = 1'b1;
            end else begin
                req_d   = 1'b1;
                erase_d = try_erase;
                addr_d  = bus_addr;
                wdata_d = cmd_data;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARRAY;
            susp_q  <= 1'b0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            susp_q  <= susp_d;
            err_q   <= err_d;
        end
    end

    // Output register toward the WSM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsm_req   <= 1'b0;
            wsm_erase <= 1'b0;
            wsm_addr  <= '0;
            wsm_wdata <= '0;
        end else begin
            wsm_req   <= req_d;
            wsm_erase <= erase_d;
            wsm_addr  <= addr_d;
            wsm_wdata <= wdata_d;
        end
    end

    assign wsm_suspend = susp_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 12,
    parameter int BLK_BITS = 3,
    parameter int DW       = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_we,
    input logic [DW-1:0] cmd_data,
    input logic          vpp_ok,
    input logic          wp_n,
    input logic          rp_hv,
    input logic          wsm_busy,
    input logic          wsm_req,
    input logic [AW-1:0] wsm_addr,
    input logic          wsm_suspend,
    input fc_state_t     state_q
);

    function automatic logic is_rsvd(input logic [7:0] c);
        return !(c inside {OP_ARRAY, OP_IDENT, OP_STATUS, OP_CLEAR, OP_ERASE,
                           OP_WRITE_A, OP_WRITE_B, OP_SUSPEND, OP_CONFIRM});
    endfunction

    logic in_read, boot_tgt;
    assign in_read  = (state_q == ST_ARRAY) || (state_q == ST_IDENT) || (state_q == ST_STATUS);
    assign boot_tgt = (wsm_addr[AW-1 -: BLK_BITS] == '0);

    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_req |=> !wsm_req);

    assert_req_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_req |-> $past(cmd_we));

    assert_vpp_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_req |-> $past(vpp_ok));

    assert_boot_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wsm_req && boot_tgt) |-> $past(wp_n || rp_hv));

    assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && in_read && is_rsvd(cmd_data[7:0])) |=> !wsm_req);

    assert_suspend_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wsm_suspend) |-> $past(cmd_we && cmd_data[7:0] == OP_SUSPEND && wsm_busy));

    assert_no_launch_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_req |-> $past(!wsm_busy && !wsm_suspend));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW), .BLK_BITS(BLK_BITS), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_data    (cmd_data),
    .vpp_ok      (vpp_ok),
    .wp_n        (wp_n),
    .rp_hv       (rp_hv),
    .wsm_busy    (wsm_busy),
    .wsm_req     (wsm_req),
    .wsm_addr    (wsm_addr),
    .wsm_suspend (wsm_suspend),
    .state_q     (state_q)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int OPLEN = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] rd_data;
    logic          vpp_ok = 1'b1;
    logic          wp_n = 1'b1;
    logic          rp_hv = 1'b0;
    logic          wsm_busy;
    logic          wsm_req, wsm_erase, wsm_suspend;
    logic [AW-1:0] wsm_addr;
    logic [DW-1:0] wsm_wdata;

    always #2.5 clk = ~clk;

    assign arr_rdata = {8'h5A, bus_addr};

    flash_cmd_ctrl #(
        .AW(AW), .BLK_BITS(2), .DW(DW), .MFR_CODE(16'h0089), .DEV_CODE(16'h0017)
    ) u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .bus_addr(bus_addr),
        .cmd_data(cmd_data), .arr_rdata(arr_rdata), .rd_data(rd_data),
        .vpp_ok(vpp_ok), .wp_n(wp_n), .rp_hv(rp_hv), .wsm_busy(wsm_busy),
        .wsm_req(wsm_req), .wsm_erase(wsm_erase), .wsm_addr(wsm_addr),
        .wsm_wdata(wsm_wdata), .wsm_suspend(wsm_suspend)
    );

    // WSM model
    int remain;
    always @(posedge clk) begin
        if (!rst_n) begin
            wsm_busy <= 1'b0;
            remain   <= 0;
        end else if (wsm_req) begin
            wsm_busy <= 1'b1;
            remain   <= OPLEN;
        end else if (remain > 0) begin
            if (wsm_suspend)
                wsm_busy <= 1'b0;
            else if (remain == 1) begin
                wsm_busy <= 1'b0;
                remain   <= 0;
            end else begin
                wsm_busy <= 1'b1;
                remain   <= remain - 1;
            end
        end
    end

    // Launch capture
    int            req_cnt = 0;
    logic          last_erase;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;
    always @(posedge clk) begin
        if (rst_n && wsm_req) begin
            req_cnt    <= req_cnt + 1;
            last_erase <= wsm_erase;
            last_addr  <= wsm_addr;
            last_data  <= wsm_wdata;
        end
    end

    int vectors = 0;
    int miscompares = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    // Scoreboard monitor: compares read data a little after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (rd_data !== e) begin
                miscompares++;
                $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd_we   = 1'b1;
        bus_addr = a;
        cmd_data = d;
        @(negedge clk);
        cmd_we   = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    task automatic chk(input int act, input int e, input string t);
        vectors++;
        if (act != e) begin
            miscompares++;
            $display("FAIL %s: actual=%0h expected=%0h", t, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 50 && wsm_busy; i++) @(negedge clk);
        idle(1);
    endtask

    logic done = 1'b0;

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state is array mode
        rd(8'h12, 16'h5A12, "R1 reset array read");
        chk(wsm_req, 0, "R1 no request at reset");
        // R2 identifier mode
        wr(8'h00, 16'h0090);
        rd(8'h00, 16'h0089, "R2 manufacturer code");
        rd(8'h01, 16'h0017, "R2 device code");
        rd(8'h02, 16'h0000, "R2 other id address");
        // R8 reserved code keeps identifier mode
        wr(8'h00, 16'h00C3);
        rd(8'h01, 16'h0017, "R8 reserved in id mode");
        // R3 status mode
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0080, "R3 idle status");
        // R1 back to array
        wr(8'h00, 16'h00FF);
        rd(8'h33, 16'h5A33, "R1 FFh returns array");
        // R8 reserved in array mode
        wr(8'h05, 16'h0033);
        idle(2);
        rd(8'h05, 16'h5A05, "R8 reserved keeps array");
        chk(req_cnt, 0, "R8 no request from reserved");
        // R4 erase
        wr(8'h80, 16'h0020);
        rd(8'h80, 16'h0080, "R9 status after erase setup");
        wr(8'h85, 16'h00D0);
        idle(2);
        chk(req_cnt, 1, "R4 erase request count");
        chk(last_erase, 1, "R4 erase flag");
        chk(last_addr, 8'h85, "R4 erase address");
        rd(8'h00, 16'h0000, "R9 busy status after erase");
        wait_ready();
        rd(8'h00, 16'h0080, "R9 ready after erase");
        // R5 word write 40h
        wr(8'hC5, 16'h0040);
        wr(8'hC5, 16'h1234);
        idle(2);
        chk(req_cnt, 2, "R5 write request count");
        chk(last_erase, 0, "R5 write flag");
        chk(last_addr, 8'hC5, "R5 write address");
        chk(last_data, 16'h1234, "R5 write data");
        // R12 launch while busy dropped
        wr(8'h90, 16'h0020);
        wr(8'h90, 16'h00D0);
        idle(1);
        chk(req_cnt, 2, "R12 no request while busy");
        rd(8'h00, 16'h0000, "R12 no error while busy");
        wait_ready();
        rd(8'h00, 16'h0080, "R12 ready again");
        // R5 word write 10h
        wr(8'h7E, 16'h0010);
        wr(8'h7E, 16'hBEEF);
        idle(2);
        chk(req_cnt, 3, "R5 alt setup request");
        chk(last_data, 16'hBEEF, "R5 alt setup data");
        // R6 suspend and resume
        wr(8'h00, 16'h00B0);
        idle(2);
        chk(wsm_suspend, 1, "R6 suspend raised");
        rd(8'h00, 16'h00C0, "R6 suspended status");
        wr(8'h00, 16'h00FF);
        rd(8'h44, 16'h5A44, "R6 array while suspended");
        wr(8'h00, 16'h00D0);
        idle(2);
        chk(wsm_suspend, 0, "R6 suspend lowered");
        rd(8'h00, 16'h0000, "R6 busy after resume");
        wait_ready();
        // R10 erase abort
        wr(8'h80, 16'h0020);
        wr(8'h80, 16'h0077);
        idle(1);
        rd(8'h00, 16'h00B0, "R10 sequence error status");
        chk(req_cnt, 3, "R10 no request on abort");
        // R3 clear keeps status mode
        wr(8'h00, 16'h0050);
        rd(8'h00, 16'h0080, "R3 clear errors");
        // R7 voltage lockout
        vpp_ok = 1'b0;
        wr(8'h40, 16'h0020);
        wr(8'h40, 16'h00D0);
        idle(1);
        rd(8'h00, 16'h00A8, "R7 vpp error on erase");
        chk(req_cnt, 3, "R7 no request with vpp low");
        wr(8'h00, 16'h00FF);
        rd(8'h22, 16'h5A22, "R7 array read with vpp low");
        vpp_ok = 1'b1;
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0080, "R7 cleared after restore");
        // R11 boot block lock
        wp_n = 1'b0;
        rp_hv = 1'b0;
        wr(8'h10, 16'h0040);
        wr(8'h10, 16'hCAFE);
        idle(1);
        rd(8'h00, 16'h0092, "R11 locked write status");
        chk(req_cnt, 3, "R11 no request when locked");
        wr(8'h00, 16'h0050);
        rp_hv = 1'b1;
        wr(8'h10, 16'h0040);
        wr(8'h10, 16'hCAFE);
        idle(2);
        chk(req_cnt, 4, "R11 request with rp_hv high");
        chk(last_addr, 8'h10, "R11 boot address");
        wait_ready();
        rd(8'h00, 16'h0080, "R11 no lock error");
        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule